// File: doc/BRIEF.md
# Optical Link Qualifier

This block decides whether the optical receive link can be trusted. It receives two inputs. The first is a flag from an external level detector that is high while the received optical power is above threshold. The second is the sliced optical bit stream. From these it drives an active-low status output and two enables, one for the fiber transmit path and one for the copper transmit path. All timing is counted in cycles of a single clock, and every duration is a parameter.

The link is good only when both conditions hold: the level flag has been qualified high, and transitions on the stream arrive closer together than a maximum gap. The level flag goes through an asymmetric filter, so declaring the level lost takes twice as many consecutive samples as declaring it present. After the good condition returns, the block waits through a settle period. It then re-enables the paths only once the stream shows idle spacing rather than densely packed data transitions. When the good condition is lost, the paths are disabled on the next clock.

Top module: `olm_link_qualifier`

## Requirements
- R1: `light_ok_n` is low only in a cycle that follows a cycle in which the level was qualified and the last transition was fewer than `TRANS_GAP` cycles old.
- R2: When the link is declared good and the good condition is lost, `light_ok_n` goes high at the next clock edge.
- R3: When transitions stop while the level stays high, `light_ok_n` goes high within `TRANS_GAP`+2 clock edges of the last transition.
- R4: In the good state, once `lvl_above` is sampled low for `2*ON_QUAL` consecutive edges, `light_ok_n` goes high exactly one edge later, which is `2*ON_QUAL`+1 edges after the first low sample. A shorter dropout leaves `light_ok_n` low.
- R5: When the level returns and transitions are spaced at idle rate, `light_ok_n` falls exactly `ON_QUAL`+`SETTLE_CYC`+1 edges after the first high sample of `lvl_above`.
- R6: The level filter needs `ON_QUAL` consecutive high samples to rise and `2*ON_QUAL` consecutive low samples to fall. A dropout or a rise shorter than these counts does not change the qualified level.
- R7: `fiber_tx_en` and `copper_tx_en` are both low whenever `light_ok_n` is high.
- R8: The stream counts as busy when the last two transitions were at most `DATA_GAP` cycles apart. If the settle period ends while the stream is busy, `light_ok_n` stays high until the spacing exceeds `DATA_GAP` cycles.
- R9: A synchronous reset drives `light_ok_n` high and both enables low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_above | input | 1 | Above-threshold flag from the level detector |
| rx_slice | input | 1 | Sliced optical bit stream |
| light_ok_n | output | 1 | Link status, low = good |
| fiber_tx_en | output | 1 | Enable for the fiber transmit path |
| copper_tx_en | output | 1 | Enable for the copper transmit path |

## Verification
Two events can land on the same edge: the end of the settle count and the data-busy decision. The bench feeds transitions spaced two cycles apart through the whole settle period, so the settle counter expires while the stream is busy. It then checks that the status stays high well past the expiry and falls within a few cycles after the spacing is widened to idle rate. The level filter's rise and fall are also timed edge-exactly against the settle length, which separates an off-side count from the on-side count.

// File: rtl/olm_pkg.sv
package olm_pkg;
  typedef enum logic [1:0] {
    ST_DARK   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_LIT    = 2'd2
  } olm_state_t;
endpackage

// File: rtl/olm_level_filter.sv
module olm_level_filter #(
  parameter int unsigned RISE_CNT = 8,
  parameter int unsigned FALL_CNT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_in,
  output logic lvl_good
);
  localparam int unsigned CW = $clog2(FALL_CNT + 1);
  localparam logic [CW-1:0] RISE_LAST = CW'(RISE_CNT - 1);
  localparam logic [CW-1:0] FALL_LAST = CW'(FALL_CNT - 1);

  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= '0;
      lvl_good <= 1'b0;
    end else if (lvl_in != lvl_good) begin
      if ((lvl_good && run == FALL_LAST) || (!lvl_good && run == RISE_LAST)) begin
        lvl_good <= lvl_in;
        run      <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end else begin
      run <= '0;
    end
  end
endmodule

// File: rtl/olm_edge_tracker.sv
module olm_edge_tracker #(
  parameter int unsigned GAP_MAX  = 300,
  parameter int unsigned BUSY_GAP = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_in,
  output logic trans_ok,
  output logic data_busy
);
  localparam int unsigned GW = $clog2(GAP_MAX + 1);
  localparam logic [GW-1:0] GAP_TOP = GW'(GAP_MAX);
  localparam logic [GW-1:0] BUSY_LIM = GW'(BUSY_GAP);

  logic          rx_q;
  logic [GW-1:0] gap;
  logic          edge_seen;

  assign edge_seen = rx_in ^ rx_q;
  assign trans_ok  = (gap < GAP_TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q      <= 1'b0;
      gap       <= GAP_TOP;
      data_busy <= 1'b0;
    end else begin
      rx_q <= rx_in;
      if (edge_seen) begin
        gap       <= '0;
        data_busy <= (gap < BUSY_LIM);
      end else begin
        if (gap != GAP_TOP) gap <= gap + 1'b1;
        if (gap >= BUSY_LIM) data_busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/olm_link_fsm.sv
module olm_link_fsm
  import olm_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic good,
  input  logic busy,
  output logic light_ok_n,
  output logic fiber_tx_en,
  output logic copper_tx_en
);
  localparam int unsigned SW = $clog2(SETTLE_CYC + 1);
  localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYC - 1);

  olm_state_t    state, nxt;
  logic [SW-1:0] scnt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_DARK:   if (good) nxt = ST_SETTLE;
      ST_SETTLE: begin
        if (!good) nxt = ST_DARK;
        else if (scnt == SETTLE_LAST && !busy) nxt = ST_LIT;
      end
      ST_LIT:    if (!good) nxt = ST_DARK;
      default:   nxt = ST_DARK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_DARK;
      scnt         <= '0;
      light_ok_n   <= 1'b1;
      fiber_tx_en  <= 1'b0;
      copper_tx_en <= 1'b0;
    end else begin
      state        <= nxt;
      light_ok_n   <= (nxt != ST_LIT);
      fiber_tx_en  <= (nxt == ST_LIT);
      copper_tx_en <= (nxt == ST_LIT);
      if (state != ST_SETTLE) scnt <= '0;
      else if (scnt != SETTLE_LAST) scnt <= scnt + 1'b1;
    end
  end
endmodule

// File: rtl/olm_link_qualifier.sv
module olm_link_qualifier #(
  parameter int unsigned TRANS_GAP  = 300,
  parameter int unsigned DATA_GAP   = 20,
  parameter int unsigned ON_QUAL    = 5000,
  parameter int unsigned SETTLE_CYC = 50000000
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_above,
  input  logic rx_slice,
  output logic light_ok_n,
  output logic fiber_tx_en,
  output logic copper_tx_en
);
  localparam int unsigned OFF_QUAL = 2 * ON_QUAL;

  logic lvl_good;
  logic trans_ok;
  logic busy;

  olm_level_filter #(.RISE_CNT(ON_QUAL), .FALL_CNT(OFF_QUAL)) u_lvl (
    .clk(clk), .rst(rst), .lvl_in(lvl_above), .lvl_good(lvl_good)
  );

  olm_edge_tracker #(.GAP_MAX(TRANS_GAP), .BUSY_GAP(DATA_GAP)) u_edge (
    .clk(clk), .rst(rst), .rx_in(rx_slice), .trans_ok(trans_ok), .data_busy(busy)
  );

  olm_link_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk(clk), .rst(rst), .good(lvl_good && trans_ok), .busy(busy),
    .light_ok_n(light_ok_n), .fiber_tx_en(fiber_tx_en), .copper_tx_en(copper_tx_en)
  );
endmodule

// File: rtl/olm_checker.sv
module olm_checker #(
  parameter int unsigned GAP_MAX = 300,
  parameter int unsigned RISE_N  = 5000,
  parameter int unsigned FALL_N  = 10000
) (
  input logic clk,
  input logic rst,
  input logic level_in,
  input logic rx_in,
  input logic light_ok_n,
  input logic fib_en,
  input logic cu_en,
  input logic lvl_good,
  input logic trans_ok,
  input logic busy
);
  localparam int unsigned CGW = $clog2(GAP_MAX + 2);
  localparam int unsigned RW  = $clog2(FALL_N + 1);

  logic           rx_prev;
  logic [CGW-1:0] ck_gap;
  logic [RW-1:0]  hi_run, lo_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_prev <= 1'b0;
      ck_gap  <= CGW'(GAP_MAX + 1);
      hi_run  <= '0;
      lo_run  <= '0;
    end else begin
      rx_prev <= rx_in;
      if (rx_in != rx_prev) ck_gap <= '0;
      else if (ck_gap != CGW'(GAP_MAX + 1)) ck_gap <= ck_gap + 1'b1;
      if (level_in) begin
        lo_run <= '0;
        if (hi_run != RW'(FALL_N)) hi_run <= hi_run + 1'b1;
      end else begin
        hi_run <= '0;
        if (lo_run != RW'(FALL_N)) lo_run <= lo_run + 1'b1;
      end
    end
  end

  AST_LIT_NEEDS_GOOD: assert property (@(posedge clk) disable iff (rst)
    !light_ok_n |-> $past(lvl_good && trans_ok)); // R1

  AST_DROP_NEXT_EDGE: assert property (@(posedge clk) disable iff (rst)
    (!light_ok_n && !(lvl_good && trans_ok)) |=> light_ok_n); // R2

  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (rst)
    !light_ok_n |-> (ck_gap <= CGW'(GAP_MAX))); // R3

  AST_RISE_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(lvl_good) |-> (hi_run >= RW'(RISE_N))); // R6

  AST_FALL_RUN: assert property (@(posedge clk) disable iff (rst)
    $fell(lvl_good) |-> (lo_run >= RW'(FALL_N))); // R4

  AST_LIT_WHEN_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(light_ok_n) |-> !$past(busy)); // R8

  AST_PATHS_OFF: assert property (@(posedge clk) disable iff (rst)
    light_ok_n |-> (!fib_en && !cu_en)); // R7
endmodule

bind olm_link_qualifier olm_checker #(
  .GAP_MAX(TRANS_GAP), .RISE_N(ON_QUAL), .FALL_N(2 * ON_QUAL)
) u_chk (
  .clk(clk), .rst(rst), .level_in(lvl_above), .rx_in(rx_slice),
  .light_ok_n(light_ok_n), .fib_en(fiber_tx_en), .cu_en(copper_tx_en),
  .lvl_good(lvl_good), .trans_ok(trans_ok), .busy(busy)
);

// File: tb/sim_olm_link_qualifier.sv
module sim_olm_link_qualifier;
  localparam int unsigned TGAP = 12;
  localparam int unsigned DGAP = 4;
  localparam int unsigned ONQ  = 8;
  localparam int unsigned SETL = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lvl = 1'b0;
  logic rx  = 1'b0;
  logic light_ok_n, fiber_tx_en, copper_tx_en;
  int   n_chk = 0;
  int   n_bad = 0;
  int   period = 0;
  int   phase = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  olm_link_qualifier #(.TRANS_GAP(TGAP), .DATA_GAP(DGAP), .ON_QUAL(ONQ), .SETTLE_CYC(SETL)) u0 (
    .clk(clk), .rst(rst), .lvl_above(lvl), .rx_slice(rx),
    .light_ok_n(light_ok_n), .fiber_tx_en(fiber_tx_en), .copper_tx_en(copper_tx_en)
  );

  // {level, toggle period (0 = none), cycles, expected light_ok_n}
  localparam logic [13:0] VEC [11] = '{
    {1'b1, 4'd6, 8'd20, 1'b1},  // R5 still settling
    {1'b1, 4'd6, 8'd30, 1'b0},  // R5 lit
    {1'b1, 4'd2, 8'd30, 1'b0},  // R1 dense data keeps link
    {1'b0, 4'd2, 8'd10, 1'b0},  // R6 short dropout ignored
    {1'b1, 4'd6, 8'd20, 1'b0},  // R6 still lit
    {1'b0, 4'd6, 8'd24, 1'b1},  // R4 level lost
    {1'b1, 4'd6, 8'd12, 1'b1},  // R5 requalifying
    {1'b1, 4'd6, 8'd40, 1'b0},  // R5 lit again
    {1'b1, 4'd0, 8'd30, 1'b1},  // R3 no transitions
    {1'b1, 4'd6, 8'd15, 1'b1},  // R5 settle after transitions return
    {1'b1, 4'd6, 8'd40, 1'b0}   // R5 lit
  };

  task automatic step();
    @(negedge clk);
    if (period != 0) begin
      if (phase >= period - 1) begin rx = ~rx; phase = 0; end
      else phase = phase + 1;
    end
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    run(3);
    check("R9 reset status", light_ok_n, 1);
    check("R9 reset enables", {fiber_tx_en, copper_tx_en}, 0);
    rst = 1'b0;

    for (int i = 0; i < 11; i++) begin
      lvl    = VEC[i][13];
      period = int'(VEC[i][12:9]);
      run(int'(VEC[i][8:1]));
      check($sformatf("R1/R2 row %0d status", i), light_ok_n, VEC[i][0]);
      check($sformatf("R7 row %0d enables", i), {fiber_tx_en, copper_tx_en},
            VEC[i][0] ? 0 : 3);
    end

    // R4: edge-exact fall of the qualified level, toggles at idle rate
    lvl = 1'b0; n = 0;
    while (light_ok_n == 1'b0 && n < 200) begin step(); n++; end
    check("R4 fall delay", n, 2 * ONQ + 1);
    // R5 / R6: edge-exact recovery including settle
    lvl = 1'b1; n = 0;
    while (light_ok_n == 1'b1 && n < 200) begin step(); n++; end
    check("R5 rise plus settle delay", n, ONQ + SETL + 1);

    // R8: settle expires while stream is busy
    lvl = 1'b0; run(30);
    check("R2 dark before busy test", light_ok_n, 1);
    lvl = 1'b1; period = 2; run(60);
    check("R8 held while busy", light_ok_n, 1);
    check("R7 paths off while busy", {fiber_tx_en, copper_tx_en}, 0);
    period = 6; run(12);
    check("R8 lit once idle", light_ok_n, 0);

    // R9: reset while lit
    rst = 1'b1; run(2);
    check("R9 reset while lit", light_ok_n, 1);
    check("R9 enables cleared", {fiber_tx_en, copper_tx_en}, 0);
    rst = 1'b0; run(45);
    check("R5 lit after reset", light_ok_n, 0);

    // R3: transitions stop
    period = 0; run(4);
    check("R3 still lit shortly after stop", light_ok_n, 0);
    run(10);
    check("R3 dark after gap", light_ok_n, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule